// File: doc/BRIEF.md
# Clock Distribution Configuration Register Slave

This block is the configuration port of an eight-output clock distribution device. It is a two-wire serial slave (SMBus / I2C style) that keeps a small register file. Software can write or read one byte at a time. The register fields leave the block as ordinary output ports and go to the output drivers and the PLL control. Every field has a reset default, so the device works with no bus traffic at all.

The bus address is not fixed. A three-level address strap chooses one of three 7-bit addresses. A second three-level strap gives the PLL operating mode. Both straps are latched once, the first time the power-good input is seen high. They are never resampled after that. Until that capture the slave answers nobody. The mode register has two PLL mode fields: a read-only copy of the latched mode strap, and a writable control field that starts out equal to the strap.

Top module: `clkcfg_smbus_slave`

## Requirements
- R1: Right after reset: `out_en` is all ones, `stop_level` is 00, `pll_mode_ctl` is 00, `cfg_ready` is 0 and `sda_oe` is 0.
- R2: Until power-good has been captured, the slave never drives SDA, so every address byte gets a NAK.
- R3: Strap codes are 00 = low, 01 = mid, 10 or 11 = high. The address strap picks address 1101011 (low), 1101100 (mid) or 1101101 (high). It is latched on the first synchronised high of `pwr_good`, and `cfg_ready` then stays 1. Later changes to the strap or to `pwr_good` have no effect.
- R4: The address byte is sent MSB first: seven address bits, then the R/W bit (1 = read). A matching address is ACKed. Any other address is NAKed, and the slave stays silent, NAKing even a matching byte, until the next START.
- R5: The command byte selects the register index. An index below 12 is ACKed. A larger index is NAKed and changes no register.
- R6: A write is START, address with W, command, one data byte. That data byte is ACKed and stored. A second data byte in the same transfer is NAKed and not stored.
- R7: A read is START, address with W, command, repeated START, address with R. The slave then returns the selected byte MSB first. While the master ACKs, the same byte is sent again. A master NAK ends the read.
- R8: Register 0 bit i enables output i and drives `out_en[i]`. Its default is 0xFF.
- R9: In register 1, bits [7:6] are a read-only copy of the strap mode and bits [4:3] are the writable control field that drives `pll_mode_ctl`. All other bits read 0. Mode encoding: 00 = PLL low bandwidth, 01 = bypass, 11 = PLL high bandwidth. The strap maps low to 00, mid to 01 and high to 11.
- R10: When power-good is captured, the control field loads the strap mode.
- R11: Register 11 bits [1:0] drive `stop_level`, and its other bits read 0. Registers 2 to 10 read 0x00, and writes to them are ACKed and ignored.
- R12: START and STOP are recognised as SDA edges while SCL is high. A STOP in the middle of a byte drops that transfer and stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Power-good level; its first high latches the straps |
| addr_strap | input | 2 | Three-level address strap code |
| mode_strap | input | 2 | Three-level PLL mode strap code |
| scl_in | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low |
| cfg_ready | output | 1 | Straps captured, slave active |
| out_en | output | N_OUT | Per-output enables |
| pll_mode_ctl | output | 2 | PLL mode control field |
| stop_level | output | 2 | Level that a disabled output pair drives |

## Verification
The assertions rely on these input assumptions:
- The strap pins are steady at the moment power-good first rises.
- SCL and SDA each hold every level for several clock cycles, so the two-flop synchronisers never merge a START into a data edge.
- The master changes SDA only while SCL is low, except when it makes a START or a STOP.

The bench master keeps ten clock cycles of setup on each side of every SCL edge. It changes straps only while reset is held, or after capture to show that they are ignored, and it drives the wire as open-drain so that the slave's pull-down always wins.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

   typedef enum logic [3:0] {
      LS_IDLE,
      LS_ADDR,
      LS_ADDR_ACK,
      LS_CMD,
      LS_CMD_ACK,
      LS_WDATA,
      LS_WDATA_ACK,
      LS_RDATA,
      LS_RACK,
      LS_SKIP
   } link_state_e;

   // three-level strap: 00 low, 01 mid, 1x high
   function automatic logic [1:0] strap_to_mode(input logic [1:0] code);
      case (code)
         2'b00:   return 2'b00;
         2'b01:   return 2'b01;
         default: return 2'b11;
      endcase
   endfunction

   function automatic logic [6:0] strap_to_addr(input logic [1:0] code,
                                                 input logic [6:0] a_lo,
                                                 input logic [6:0] a_mid,
                                                 input logic [6:0] a_hi);
      case (code)
         2'b00:   return a_lo;
         2'b01:   return a_mid;
         default: return a_hi;
      endcase
   endfunction

endpackage

// File: rtl/clkcfg_sync.sv
module clkcfg_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("clkcfg_sync needs at least two stages");
      end
      for (genvar b = 0; b < W; b++) begin : g_bit
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], d[b]};
         end
         assign q[b] = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/clkcfg_bus_cond.sv
module clkcfg_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic start_p,
   output logic stop_p,
   output logic scl_rise,
   output logic scl_fall
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   // data line edges while the clock line stays high
   assign start_p  = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_p   = scl_s & scl_p & ~sda_p & sda_s;
   assign scl_rise = scl_s & ~scl_p;
   assign scl_fall = ~scl_s & scl_p;
endmodule

// File: rtl/clkcfg_strap_cap.sv
module clkcfg_strap_cap
   import clkcfg_pkg::*;
#(
   parameter logic [6:0] ADDR_LO  = 7'b1101011,
   parameter logic [6:0] ADDR_MID = 7'b1101100,
   parameter logic [6:0] ADDR_HI  = 7'b1101101
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pg_s,
   input  logic [1:0] addr_strap,
   input  logic [1:0] mode_strap,
   output logic       ready,
   output logic       cap_pulse,
   output logic [6:0] bus_addr,
   output logic [1:0] mode_rb
);
   assign cap_pulse = pg_s & ~ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready    <= 1'b0;
         bus_addr <= ADDR_LO;
         mode_rb  <= 2'b00;
      end else if (cap_pulse) begin
         ready    <= 1'b1;
         bus_addr <= strap_to_addr(addr_strap, ADDR_LO, ADDR_MID, ADDR_HI);
         mode_rb  <= strap_to_mode(mode_strap);
      end
   end
endmodule

// File: rtl/clkcfg_regfile.sv
module clkcfg_regfile #(
   parameter int N_OUT    = 8,
   parameter int NUM_REGS = 12,
   parameter int IDX_EN   = 0,
   parameter int IDX_MODE = 1,
   parameter int IDX_STOP = 11,
   parameter int IDX_W    = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [7:0]       wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [7:0]       rd_data,
   input  logic             cap_pulse,
   input  logic [1:0]       cap_mode,
   input  logic [1:0]       mode_rb,
   output logic [N_OUT-1:0] out_en,
   output logic [1:0]       pll_mode_ctl,
   output logic [1:0]       stop_level
);
   logic [7:0] view [NUM_REGS];

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
         wire hit = wr_en && (wr_idx == MY_IDX);

         if (i == IDX_EN) begin : g_en
            logic [N_OUT-1:0] en_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   en_q <= '1;
               else if (hit) en_q <= wr_data[N_OUT-1:0];
            end
            assign out_en  = en_q;
            assign view[i] = 8'(en_q);
         end else if (i == IDX_MODE) begin : g_mode
            logic [1:0] ctl_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)         ctl_q <= 2'b00;
               else if (cap_pulse) ctl_q <= cap_mode;
               else if (hit)       ctl_q <= wr_data[4:3];
            end
            assign pll_mode_ctl = ctl_q;
            assign view[i]      = {mode_rb, 1'b0, ctl_q, 3'b000};
         end else if (i == IDX_STOP) begin : g_stop
            logic [1:0] lvl_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   lvl_q <= 2'b00;
               else if (hit) lvl_q <= wr_data[1:0];
            end
            assign stop_level = lvl_q;
            assign view[i]    = {6'b0, lvl_q};
         end else begin : g_hole
            assign view[i] = 8'h00;
         end
      end
   endgenerate

   always_comb begin
      rd_data = 8'h00;
      for (int k = 0; k < NUM_REGS; k++)
         if (rd_idx == IDX_W'(k)) rd_data = view[k];
   end
endmodule

// File: rtl/clkcfg_link.sv
module clkcfg_link
   import clkcfg_pkg::*;
#(
   parameter int NUM_REGS = 12,
   parameter int IDX_W    = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_p,
   input  logic             stop_p,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             sda_s,
   input  logic             ready,
   input  logic [6:0]       bus_addr,
   input  logic [7:0]       rd_data,
   output logic             sda_oe,
   output logic             wr_en,
   output logic [IDX_W-1:0] reg_idx,
   output logic [7:0]       wr_data
);
   localparam logic [7:0] NREG8 = 8'(NUM_REGS);

   link_state_e state;
   logic [3:0]  cnt;
   logic [7:0]  sh;
   logic        rw;
   logic        mst_ack;

   wire rx_done = scl_fall && (cnt == 4'd8);
   assign wr_data = sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= LS_IDLE;
         cnt     <= 4'd0;
         sh      <= 8'h00;
         rw      <= 1'b0;
         mst_ack <= 1'b0;
         sda_oe  <= 1'b0;
         wr_en   <= 1'b0;
         reg_idx <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_p) begin
            state  <= LS_ADDR;
            cnt    <= 4'd0;
            sda_oe <= 1'b0;
         end else if (stop_p) begin
            state  <= LS_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               LS_ADDR, LS_CMD, LS_WDATA: begin
                  if (scl_rise && cnt != 4'd8) begin
                     sh  <= {sh[6:0], sda_s};
                     cnt <= cnt + 4'd1;
                  end else if (rx_done) begin
                     if (state == LS_ADDR) begin
                        if (ready && sh[7:1] == bus_addr) begin
                           rw     <= sh[0];
                           sda_oe <= 1'b1;
                           state  <= LS_ADDR_ACK;
                        end else begin
                           state <= LS_SKIP;
                        end
                     end else if (state == LS_CMD) begin
                        if (sh < NREG8) begin
                           reg_idx <= sh[IDX_W-1:0];
                           sda_oe  <= 1'b1;
                           state   <= LS_CMD_ACK;
                        end else begin
                           state <= LS_SKIP;
                        end
                     end else begin
                        wr_en  <= 1'b1;
                        sda_oe <= 1'b1;
                        state  <= LS_WDATA_ACK;
                     end
                  end
               end
               LS_ADDR_ACK: if (scl_fall) begin
                  cnt <= 4'd0;
                  if (rw) begin
                     sh     <= rd_data;
                     sda_oe <= ~rd_data[7];
                     state  <= LS_RDATA;
                  end else begin
                     sda_oe <= 1'b0;
                     state  <= LS_CMD;
                  end
               end
               LS_CMD_ACK: if (scl_fall) begin
                  sda_oe <= 1'b0;
                  cnt    <= 4'd0;
                  state  <= LS_WDATA;
               end
               LS_WDATA_ACK: if (scl_fall) begin
                  sda_oe <= 1'b0;
                  state  <= LS_SKIP;
               end
               LS_RDATA: begin
                  if (scl_rise) begin
                     cnt <= cnt + 4'd1;
                  end else if (scl_fall) begin
                     if (cnt == 4'd8) begin
                        sda_oe <= 1'b0;
                        state  <= LS_RACK;
                     end else begin
                        sh     <= {sh[6:0], 1'b0};
                        sda_oe <= ~sh[6];
                     end
                  end
               end
               LS_RACK: begin
                  if (scl_rise) begin
                     mst_ack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (mst_ack) begin
                        sh     <= rd_data;
                        sda_oe <= ~rd_data[7];
                        cnt    <= 4'd0;
                        state  <= LS_RDATA;
                     end else begin
                        state <= LS_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/clkcfg_smbus_slave.sv
module clkcfg_smbus_slave
   import clkcfg_pkg::*;
#(
   parameter int         N_OUT       = 8,
   parameter int         NUM_REGS    = 12,
   parameter int         IDX_EN      = 0,
   parameter int         IDX_MODE    = 1,
   parameter int         IDX_STOP    = 11,
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] ADDR_LO     = 7'b1101011,
   parameter logic [6:0] ADDR_MID    = 7'b1101100,
   parameter logic [6:0] ADDR_HI     = 7'b1101101
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_good,
   input  logic [1:0]       addr_strap,
   input  logic [1:0]       mode_strap,
   input  logic             scl_in,
   input  logic             sda_in,
   output logic             sda_oe,
   output logic             cfg_ready,
   output logic [N_OUT-1:0] out_en,
   output logic [1:0]       pll_mode_ctl,
   output logic [1:0]       stop_level
);
   localparam int IDX_W = $clog2(NUM_REGS);

   generate
      if (N_OUT < 1 || N_OUT > 8) begin : g_bad_nout
         $error("N_OUT must be 1..8");
      end
      if (NUM_REGS < 2 || NUM_REGS > 256) begin : g_bad_nregs
         $error("NUM_REGS must be 2..256");
      end
      if (IDX_EN >= NUM_REGS || IDX_MODE >= NUM_REGS || IDX_STOP >= NUM_REGS) begin : g_bad_idx
         $error("register index outside the file");
      end
      if (IDX_EN == IDX_MODE || IDX_EN == IDX_STOP || IDX_MODE == IDX_STOP) begin : g_dup_idx
         $error("register indices must differ");
      end
   endgenerate

   logic       pg_s, scl_q, sda_q;
   logic       start_p, stop_p, scl_rise, scl_fall;
   logic       cap_pulse;
   logic [6:0] bus_addr;
   logic [1:0] mode_rb;
   logic       wr_en;
   logic [IDX_W-1:0] reg_idx;
   logic [7:0] wr_data, rd_data;

   clkcfg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({pwr_good, scl_in, sda_in}),
      .q({pg_s, scl_q, sda_q})
   );

   clkcfg_bus_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_q), .sda_s(sda_q),
      .start_p(start_p), .stop_p(stop_p), .scl_rise(scl_rise), .scl_fall(scl_fall)
   );

   clkcfg_strap_cap #(.ADDR_LO(ADDR_LO), .ADDR_MID(ADDR_MID), .ADDR_HI(ADDR_HI)) u_strap (
      .clk(clk), .rst_n(rst_n), .pg_s(pg_s),
      .addr_strap(addr_strap), .mode_strap(mode_strap),
      .ready(cfg_ready), .cap_pulse(cap_pulse),
      .bus_addr(bus_addr), .mode_rb(mode_rb)
   );

   clkcfg_link #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_link (
      .clk(clk), .rst_n(rst_n),
      .start_p(start_p), .stop_p(stop_p), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_s(sda_q), .ready(cfg_ready), .bus_addr(bus_addr), .rd_data(rd_data),
      .sda_oe(sda_oe), .wr_en(wr_en), .reg_idx(reg_idx), .wr_data(wr_data)
   );

   clkcfg_regfile #(
      .N_OUT(N_OUT), .NUM_REGS(NUM_REGS), .IDX_EN(IDX_EN),
      .IDX_MODE(IDX_MODE), .IDX_STOP(IDX_STOP), .IDX_W(IDX_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(reg_idx), .wr_data(wr_data),
      .rd_idx(reg_idx), .rd_data(rd_data),
      .cap_pulse(cap_pulse), .cap_mode(strap_to_mode(mode_strap)), .mode_rb(mode_rb),
      .out_en(out_en), .pll_mode_ctl(pll_mode_ctl), .stop_level(stop_level)
   );
endmodule

// File: rtl/clkcfg_smbus_chk.sv
module clkcfg_smbus_chk #(
   parameter int N_OUT = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sda_oe,
   input logic             cfg_ready,
   input logic             scl_q,
   input logic [6:0]       bus_addr,
   input logic [N_OUT-1:0] out_en,
   input logic [1:0]       stop_level,
   input logic [1:0]       pll_mode_ctl,
   input logic             wr_en,
   input logic             cap_pulse
);
   // R2: silent until the straps are captured
   a_r2_quiet_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_ready |-> !sda_oe);

   // R3: capture happens once and holds
   a_r3_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ready |=> cfg_ready);

   a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_ready && $past(cfg_ready)) |-> $stable(bus_addr));

   // R12: the slave starts pulling SDA only while SCL is low
   a_r12_drive_on_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_q);

   // R8: enables move only on an accepted data byte
   a_r8_en_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(out_en) |-> $past(wr_en));

   // R11: stop level moves only on an accepted data byte
   a_r11_stop_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(stop_level) |-> $past(wr_en));

   // R10: mode control moves only on capture or a write
   a_r10_ctl_cause: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pll_mode_ctl) |-> $past(wr_en || cap_pulse));
endmodule

bind clkcfg_smbus_slave clkcfg_smbus_chk #(.N_OUT(N_OUT)) u_chk (
   .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .cfg_ready(cfg_ready),
   .scl_q(scl_q), .bus_addr(bus_addr), .out_en(out_en),
   .stop_level(stop_level), .pll_mode_ctl(pll_mode_ctl),
   .wr_en(wr_en), .cap_pulse(cap_pulse)
);

// File: tb/sim_clkcfg_smbus_slave.sv
module sim_clkcfg_smbus_slave;
   localparam int Q = 10;
   localparam int H = 20;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n, pwr_good;
   logic [1:0] addr_strap, mode_strap;
   logic       scl_m, sda_m, sda_line;
   logic       sda_oe, cfg_ready;
   logic [7:0] out_en;
   logic [1:0] pll_mode_ctl, stop_level;

   assign sda_line = sda_m & ~sda_oe;

   clkcfg_smbus_slave u0 (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
      .addr_strap(addr_strap), .mode_strap(mode_strap),
      .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
      .cfg_ready(cfg_ready), .out_en(out_en),
      .pll_mode_ctl(pll_mode_ctl), .stop_level(stop_level)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   typedef struct { logic [7:0] v; string req; } exp_t;
   exp_t       exp_q[$];
   logic [7:0] obs_q[$];

   task automatic expect_b(input logic [7:0] v, input string req);
      exp_t e;
      e.v = v; e.req = req;
      exp_q.push_back(e);
   endtask

   // monitor: pops bus observations and compares with the queued expectations
   always @(negedge clk) begin
      if (obs_q.size() != 0) begin
         logic [7:0] o;
         exp_t e;
         o = obs_q.pop_front();
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL bus: unexpected item actual=%02h expected=none", o);
         end else begin
            e = exp_q.pop_front();
            if (o !== e.v) begin
               bad++;
               $display("FAIL %s: bus actual=%02h expected=%02h", e.req, o, e.v);
            end
         end
      end
   end

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s: port actual=%02h expected=%02h", req, act, expv);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wait_clk(Q);
      scl_m = 1'b1; wait_clk(Q);
      sda_m = 1'b0; wait_clk(Q);
      scl_m = 1'b0; wait_clk(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wait_clk(Q);
      scl_m = 1'b1; wait_clk(Q);
      sda_m = 1'b1; wait_clk(Q);
   endtask

   task automatic put_bit(input logic b);
      sda_m = b;    wait_clk(Q);
      scl_m = 1'b1; wait_clk(H);
      scl_m = 1'b0; wait_clk(Q);
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1'b1; wait_clk(Q);
      scl_m = 1'b1; wait_clk(H / 2);
      b = sda_line; wait_clk(H / 2);
      scl_m = 1'b0; wait_clk(Q);
   endtask

   task automatic send_byte(input logic [7:0] b);
      logic a;
      for (int i = 7; i >= 0; i--) put_bit(b[i]);
      get_bit(a);
      obs_q.push_back({7'd0, ~a});
   endtask

   task automatic recv_byte(input logic more);
      logic [7:0] d;
      logic bt;
      for (int i = 7; i >= 0; i--) begin
         get_bit(bt);
         d[i] = bt;
      end
      obs_q.push_back(d);
      put_bit(~more);
   endtask

   task automatic wr_reg(input logic [6:0] a, input logic [7:0] idx, input logic [7:0] d,
                         input logic ea, input logic ec, input logic ed, input string req);
      expect_b({7'd0, ea}, req);
      bus_start();
      send_byte({a, 1'b0});
      if (ea) begin
         expect_b({7'd0, ec}, req);
         send_byte(idx);
         if (ec) begin
            expect_b({7'd0, ed}, req);
            send_byte(d);
         end
      end
      bus_stop();
   endtask

   task automatic rd_reg(input logic [6:0] a, input logic [7:0] idx, input logic [7:0] ev,
                         input int n, input string req);
      expect_b(8'd1, req);
      expect_b(8'd1, req);
      expect_b(8'd1, req);
      bus_start();
      send_byte({a, 1'b0});
      send_byte(idx);
      bus_start();
      send_byte({a, 1'b1});
      for (int k = 0; k < n; k++) begin
         expect_b(ev, req);
         recv_byte(k < n - 1);
      end
      bus_stop();
   endtask

   task automatic reset_dut(input logic [1:0] as, input logic [1:0] ms);
      rst_n = 1'b0; pwr_good = 1'b0;
      addr_strap = as; mode_strap = ms;
      scl_m = 1'b1; sda_m = 1'b1;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
   endtask

   task automatic power_up();
      pwr_good = 1'b1;
      wait_clk(8);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // phase A: address strap mid, mode strap high
      reset_dut(2'b01, 2'b10);
      chk("R1", out_en, 8'hFF);
      chk("R1", {6'd0, stop_level}, 8'h00);
      chk("R1", {6'd0, pll_mode_ctl}, 8'h00);
      chk("R1", {7'd0, cfg_ready}, 8'h00);
      chk("R1", {7'd0, sda_oe}, 8'h00);

      wr_reg(7'b1101100, 8'd0, 8'h00, 1'b0, 1'b0, 1'b0, "R2");
      chk("R2", out_en, 8'hFF);

      power_up();
      chk("R3", {7'd0, cfg_ready}, 8'h01);
      chk("R10", {6'd0, pll_mode_ctl}, 8'h03);

      // strap and power-good changes after capture are ignored
      addr_strap = 2'b00; mode_strap = 2'b00;
      pwr_good = 1'b0; wait_clk(8);
      pwr_good = 1'b1; wait_clk(8);
      chk("R3", {7'd0, cfg_ready}, 8'h01);
      chk("R10", {6'd0, pll_mode_ctl}, 8'h03);
      wr_reg(7'b1101011, 8'd0, 8'h00, 1'b0, 1'b0, 1'b0, "R3");
      rd_reg(7'b1101100, 8'd1, 8'hD8, 1, "R9");

      // enables: single byte write, second byte refused
      wr_reg(7'b1101100, 8'd0, 8'hA5, 1'b1, 1'b1, 1'b1, "R8");
      chk("R8", out_en, 8'hA5);
      expect_b(8'd1, "R6"); expect_b(8'd1, "R6");
      expect_b(8'd1, "R6"); expect_b(8'd0, "R6");
      bus_start();
      send_byte({7'b1101100, 1'b0});
      send_byte(8'd0);
      send_byte(8'h5A);
      send_byte(8'h3C);
      bus_stop();
      chk("R6", out_en, 8'h5A);
      rd_reg(7'b1101100, 8'd0, 8'h5A, 3, "R7");

      // mode register
      wr_reg(7'b1101100, 8'd1, 8'h08, 1'b1, 1'b1, 1'b1, "R9");
      chk("R9", {6'd0, pll_mode_ctl}, 8'h01);
      rd_reg(7'b1101100, 8'd1, 8'hC8, 1, "R9");
      wr_reg(7'b1101100, 8'd1, 8'hFF, 1'b1, 1'b1, 1'b1, "R9");
      chk("R9", {6'd0, pll_mode_ctl}, 8'h03);
      rd_reg(7'b1101100, 8'd1, 8'hD8, 1, "R9");

      // stop level and unused registers
      wr_reg(7'b1101100, 8'd11, 8'hFF, 1'b1, 1'b1, 1'b1, "R11");
      chk("R11", {6'd0, stop_level}, 8'h03);
      rd_reg(7'b1101100, 8'd11, 8'h03, 1, "R11");
      wr_reg(7'b1101100, 8'd11, 8'h02, 1'b1, 1'b1, 1'b1, "R11");
      chk("R11", {6'd0, stop_level}, 8'h02);
      wr_reg(7'b1101100, 8'd5, 8'h77, 1'b1, 1'b1, 1'b1, "R11");
      rd_reg(7'b1101100, 8'd5, 8'h00, 1, "R11");
      chk("R11", out_en, 8'h5A);

      // command index range
      wr_reg(7'b1101100, 8'd12, 8'h00, 1'b1, 1'b0, 1'b0, "R5");
      wr_reg(7'b1101100, 8'h80, 8'h00, 1'b1, 1'b0, 1'b0, "R5");
      chk("R5", out_en, 8'h5A);

      // wrong address, then silence until next START
      expect_b(8'd0, "R4"); expect_b(8'd0, "R4");
      bus_start();
      send_byte({7'b1101101, 1'b0});
      send_byte({7'b1101100, 1'b0});
      bus_stop();
      wr_reg(7'b1101010, 8'd0, 8'h00, 1'b0, 1'b0, 1'b0, "R4");
      chk("R4", out_en, 8'h5A);

      // STOP in the middle of a data byte
      expect_b(8'd1, "R12"); expect_b(8'd1, "R12");
      bus_start();
      send_byte({7'b1101100, 1'b0});
      send_byte(8'd0);
      put_bit(1'b0); put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
      bus_stop();
      chk("R12", out_en, 8'h5A);
      wr_reg(7'b1101100, 8'd0, 8'h0F, 1'b1, 1'b1, 1'b1, "R12");
      chk("R12", out_en, 8'h0F);

      // phase B: strap low, mode low
      reset_dut(2'b00, 2'b00);
      power_up();
      chk("R10", {6'd0, pll_mode_ctl}, 8'h00);
      rd_reg(7'b1101011, 8'd1, 8'h00, 1, "R3");

      // phase C: strap high, mode mid
      reset_dut(2'b10, 2'b01);
      power_up();
      chk("R10", {6'd0, pll_mode_ctl}, 8'h01);
      rd_reg(7'b1101101, 8'd1, 8'h48, 1, "R3");

      wait_clk(20);
      while (exp_q.size() != 0) begin
         exp_t e;
         e = exp_q.pop_front();
         total++; bad++;
         $display("FAIL %s: bus actual=none expected=%02h", e.req, e.v);
      end
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule